// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block is the master side of a read-only serial link to a two-channel, 14-bit analog-to-digital converter. A one-cycle request on `start_i` while the block is idle raises the conversion strobe for one serial half-period. The strobe makes the converter sample both analog inputs at once. The block then produces exactly 34 serial clocks. On the rising serial clock edges it shifts in the channel 0 word and then the channel 1 word. Each word arrives most significant bit first and is framed by undriven gap bits, which the block drops.

When the last serial clock of the frame has finished, both words appear on the outputs. Each is sign-extended from 14 to 16 bits, and a one-cycle valid pulse marks them. The converter hands out results one sample late, so the words of a frame belong to the strobe before it. The first frame after reset therefore returns stale data. System software pairs each result with the earlier request. The serial clock half-period is a parameter given in system clocks. It is chosen so that the converter's minimum strobe width and its minimum clock high and low times are met.

Top module: `adc_capture_ctrl`

## Requirements
- R1: After reset and whenever `busy_o` is low, `conv_o` and `sclk_o` are low and `valid_o` is low; `ch0_o` and `ch1_o` reset to zero.
- R2: A `start_i` high at a clock edge while idle makes `conv_o` and `busy_o` high from that edge on; `conv_o` stays high for exactly HALF_DIV system clocks.
- R3: Each frame has exactly 34 serial clock pulses after the strobe, each high for HALF_DIV system clocks; `conv_o` and `sclk_o` are never high together.
- R4: `sdi_i` is sampled at each rising serial clock edge; counting those edges from 1, edges 3 to 16 carry the channel 0 word, bit 13 first, and appear on `ch0_o`.
- R5: Edges 19 to 32 carry the channel 1 word, bit 13 first, and appear on `ch1_o`.
- R6: The values on `sdi_i` at edges 1, 2, 17, 18, 33 and 34 have no effect on either output word.
- R7: Each 14-bit word is two's complement; bits 15 and 14 of the output repeat bit 13.
- R8: One system clock after the high phase of the 34th serial clock ends, `valid_o` is high for exactly one cycle, `busy_o` is low in that same cycle, and both words change only then.
- R9: `start_i` while `busy_o` is high is ignored: the running frame keeps its single strobe and its 34 clocks.
- R10: A `start_i` in the cycle where `valid_o` is high starts the next frame at once, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one acquisition |
| conv_o | output | 1 | Conversion strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle pulse: new words on ch0_o and ch1_o |
| ch0_o | output | OUT_W | Channel 0 result, sign-extended |
| ch1_o | output | OUT_W | Channel 1 result, sign-extended |

## Verification
The end-of-frame result pulse and the acceptance of a new request can fall in the same cycle. The bench raises `start_i` exactly in the cycle where `valid_o` is high. It then checks two things. The words of the finishing frame must be intact. The next strobe must appear in the following cycle with a full 34-clock frame behind it. The bench also drives `start_i` at random points inside running frames. A request that was wrongly accepted would show up as a longer strobe count or a wrong number of serial clocks.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_LOW,
    ST_HIGH
  } seq_state_e;
endpackage

// File: rtl/adc_cap_tick.sv
module adc_cap_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_cap_seq.sv
module adc_cap_seq
  import adc_cap_pkg::*;
#(
  parameter int FRAME_LEN = 34,
  parameter int IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             conv_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             sample_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             conv_q, sclk_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sample_o = 1'b0;
    done_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CONV;
        cnt_d   = '0;
      end
      ST_CONV: if (tick_i) state_d = ST_LOW;
      ST_LOW: if (tick_i) begin
        state_d  = ST_HIGH;
        cnt_d    = cnt_q + 1'b1;
        sample_o = 1'b1;
      end
      ST_HIGH: if (tick_i) begin
        if (cnt_q == LAST_BIT) begin
          state_d = ST_IDLE;
          done_o  = 1'b1;
        end else begin
          state_d = ST_LOW;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // index of the bit captured on the rising edge being produced
  assign bit_idx_o = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      conv_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      conv_q  <= (state_d == ST_CONV);
      sclk_q  <= (state_d == ST_HIGH);
    end
  end

  assign conv_o = conv_q;
  assign sclk_o = sclk_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_cap_word.sv
module adc_cap_word #(
  parameter int DATA_W = 14,
  parameter int OUT_W  = 16,
  parameter int IDX_W  = 6,
  parameter int FIRST  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             sdi_i,
  input  logic             load_i,
  output logic [OUT_W-1:0] word_o
);
  localparam logic [IDX_W-1:0] LO = IDX_W'(FIRST);
  localparam logic [IDX_W-1:0] HI = IDX_W'(FIRST + DATA_W - 1);
  localparam int EXT_W = OUT_W - DATA_W;

  logic [DATA_W-1:0] sr_q;
  logic              in_win;

  assign in_win = (bit_idx_i >= LO) && (bit_idx_i <= HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_q <= '0;
    else if (sample_i && in_win) sr_q <= {sr_q[DATA_W-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (load_i) word_o <= {{EXT_W{sr_q[DATA_W-1]}}, sr_q};
  end
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int HALF_DIV  = 2,
  parameter int DATA_W    = 14,
  parameter int OUT_W     = 16,
  parameter int FRAME_LEN = 34,
  parameter int CH0_FIRST = 3,
  parameter int CH1_FIRST = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             conv_o,
  output logic             sclk_o,
  input  logic             sdi_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] ch0_o,
  output logic [OUT_W-1:0] ch1_o
);
  localparam int IDX_W  = $clog2(FRAME_LEN + 1);
  localparam int NUM_CH = 2;

  logic             tick, sample, done;
  logic [IDX_W-1:0] bit_idx;
  logic [NUM_CH-1:0][OUT_W-1:0] words;

  adc_cap_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  adc_cap_seq #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tick_i    (tick),
    .conv_o    (conv_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .sample_o  (sample),
    .bit_idx_o (bit_idx),
    .done_o    (done)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    adc_cap_word #(
      .DATA_W (DATA_W),
      .OUT_W  (OUT_W),
      .IDX_W  (IDX_W),
      .FIRST  ((c == 0) ? CH0_FIRST : CH1_FIRST)
    ) u_word (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sample_i  (sample),
      .bit_idx_i (bit_idx),
      .sdi_i     (sdi_i),
      .load_i    (done),
      .word_o    (words[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= done;
  end

  assign ch0_o = words[0];
  assign ch1_o = words[1];
endmodule

// File: rtl/adc_capture_ctrl_chk.sv
module adc_capture_ctrl_chk #(
  parameter int HALF_DIV  = 2,
  parameter int FRAME_LEN = 34,
  parameter int OUT_W     = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             conv_o,
  input logic             sclk_o,
  input logic             sdi_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] ch0_o,
  input logic [OUT_W-1:0] ch1_o
);
  logic        sclk_d;
  logic [7:0]  rise_cnt;
  logic [15:0] conv_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
      conv_len <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (conv_o)                rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      if (conv_o) conv_len <= conv_len + 1'b1;
      else        conv_len <= '0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!conv_o && !sclk_o));

  // R2
  strobe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_o && conv_len != 0) |-> (conv_len == 16'(HALF_DIV)));

  // R9
  strobe_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $rose(busy_o));

  // R3
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_o && sclk_o));

  // R3
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rise_cnt == 8'(FRAME_LEN)));

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  valid_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!busy_o && $past(busy_o)));

  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(ch0_o) && $stable(ch1_o)));
endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(
  .HALF_DIV  (HALF_DIV),
  .FRAME_LEN (FRAME_LEN),
  .OUT_W     (OUT_W)
) u_chk (.*);

// File: tb/tb_adc_capture_ctrl.sv
`timescale 1ns/1ps
module tb_adc_capture_ctrl;
  localparam int HALF_DIV = 2;
  localparam int FRAME    = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sdi = 1'b0;
  logic        conv, sclk, busy, valid;
  logic [15:0] ch0, ch1;

  int n_chk = 0;
  int n_fail = 0;

  logic [13:0] adc_w0 = '0, adc_w1 = '0;
  bit          gap_ones = 1'b0;
  int          pos = 0;

  always #2.5 clk = ~clk;

  adc_capture_ctrl #(.HALF_DIV(HALF_DIV)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .conv_o  (conv),
    .sclk_o  (sclk),
    .sdi_i   (sdi),
    .busy_o  (busy),
    .valid_o (valid),
    .ch0_o   (ch0),
    .ch1_o   (ch1)
  );

  function automatic logic [15:0] sx(input logic [13:0] w);
    return {{2{w[13]}}, w};
  endfunction

  function automatic logic bit_at(input int p);
    if (p >= 3 && p <= 16)  return adc_w0[16-p];
    if (p >= 19 && p <= 32) return adc_w1[32-p];
    return gap_ones ? 1'b1 : 1'($urandom);
  endfunction

  // converter model: next bit after strobe and after each falling serial edge
  initial forever begin
    @(posedge conv or negedge sclk);
    if (conv) pos = 1;
    else      pos = pos + 1;
    sdi = bit_at(pos);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // entered at the negedge after the start cycle; leaves at the negedge with valid high
  task automatic finish_frame(input logic [13:0] a, input logic [13:0] b,
                              input bit poke, input string tag);
    int conv_len = 0;
    int rises = 0;
    int hi_cyc = 0;
    int wd = 0;
    logic prev_s = 1'b0;
    int poke_at = 4 + $urandom_range(0, 100);
    chk(conv && busy, {"R2 strobe+busy ", tag}, {conv, busy}, 3);
    while (!valid && wd < 5000) begin
      if (conv) conv_len++;
      if (sclk) hi_cyc++;
      if (sclk && !prev_s) rises++;
      prev_s = sclk;
      start = poke && (wd == poke_at);
      @(negedge clk);
      wd++;
    end
    start = 1'b0;
    chk(wd < 5000, {"R8 valid seen ", tag}, wd, 0);
    chk(conv_len == HALF_DIV, {"R2 strobe width ", tag}, conv_len, HALF_DIV);
    chk(rises == FRAME, {"R3 clock count ", tag}, rises, FRAME);
    chk(hi_cyc == FRAME * HALF_DIV, {"R3 high time ", tag}, hi_cyc, FRAME * HALF_DIV);
    chk(ch0 == sx(a), {"R4 ch0 word ", tag}, ch0, sx(a));
    chk(ch1 == sx(b), {"R5 ch1 word ", tag}, ch1, sx(b));
    chk(!busy, {"R8 busy low at valid ", tag}, busy, 0);
  endtask

  task automatic one_frame(input logic [13:0] a, input logic [13:0] b,
                           input bit ones, input bit poke, input string tag);
    adc_w0 = a; adc_w1 = b; gap_ones = ones;
    launch();
    finish_frame(a, b, poke, tag);
    @(negedge clk);
    chk(!valid && !busy && !conv && !sclk, {"R8 one-cycle valid ", tag},
        {valid, busy, conv, sclk}, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7011));
    repeat (3) @(negedge clk);
    chk(!conv && !sclk && !busy && !valid, "R1 reset outputs", {conv, sclk, busy, valid}, 0);
    chk(ch0 == 0 && ch1 == 0, "R1 reset words", {ch0, ch1}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!conv && !sclk && !busy, "R1 idle after reset", {conv, sclk, busy}, 0);

    one_frame(14'h0000, 14'h0000, 1'b1, 1'b0, "R6 ones in gaps");
    one_frame(14'h3FFF, 14'h3FFF, 1'b0, 1'b0, "R6 random gaps");
    one_frame(14'h2000, 14'h1FFF, 1'b0, 1'b0, "R7 extremes");
    one_frame(14'h3FFF, 14'h0001, 1'b1, 1'b0, "R7 minus one");
    one_frame(14'h1555, 14'h2AAA, 1'b0, 1'b1, "R9 order+poke");

    // R10: request in the valid cycle
    adc_w0 = 14'h0ABC; adc_w1 = 14'h3123; gap_ones = 1'b0;
    launch();
    finish_frame(14'h0ABC, 14'h3123, 1'b0, "R10 first");
    adc_w0 = 14'h2345; adc_w1 = 14'h0F0F;
    chk(valid, "R10 valid before restart", valid, 1);
    launch();
    finish_frame(14'h2345, 14'h0F0F, 1'b0, "R10 chained");
    @(negedge clk);
    chk(!valid && !busy, "R10 idle after chain", {valid, busy}, 0);

    for (int i = 0; i < 20; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      one_frame(14'($urandom), 14'($urandom), 1'($urandom), 1'($urandom), "R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule